// File: doc/BRIEF.md
# DMA Channel Block and Transfer Counter

This block is the counting core of a single DMA channel. It tracks two quantities. The first is how many data units remain in the block being moved. The second is how many blocks remain before the whole job ends. Software programs a block-size field and a transfer-count value through a small register port. Each value lands in a reload copy. Reading the port returns those reload copies and never the live counters.

The transfer engine works through a handshake. It raises `req` to open a block, then pulses `unit_done` once for each unit it moves. When the last unit of a block is moved, the block flags block-done. When the last block of the job is moved, it also flags terminal count. If count reload is enabled, the transfer count reloads itself and the channel keeps running. Otherwise the channel drops its enable.

Top module: `dma_chan_counter`

## Requirements
- R1: After reset, `ch_active`, `blk_busy`, `blk_done` and `term_cnt` are low, and reading the count register (`reg_sel`=1) returns 0.
- R2: A read with `reg_sel`=0 returns the programmed 4-bit block size in bits 3:0, with the upper bits zero. A read with `reg_sel`=1 returns the programmed 16-bit count. Both reads return the reload copies, including while a job runs.
- R3: A `req` sampled while the channel is active and no block is open starts a block. In normal mode the block holds the programmed number of units (1 to 15). `blk_done` is high for exactly one cycle, in the cycle after the edge that sampled the block's last `unit_done`.
- R4: A block-size value of 0 gives a block of 16 units.
- R5: When `demand_mode` is 1 at the request, the block is exactly one unit, whatever the programmed size.
- R6: A `unit_done` with no open block is ignored. A `req` while a block is open, or while the channel is inactive, is ignored.
- R7: Each block-done decrements the live transfer count by one. When the count goes from 1 to 0, `term_cnt` is high for one cycle, together with that `blk_done`.
- R8: A transfer count of 0 loaded at start means 65536 blocks.
- R9: When `reload_en` is 1 at terminal count, the live count reloads from the count reload copy and `ch_active` stays high.
- R10: When `reload_en` is 0 at terminal count, `ch_active` falls in the same cycle as `term_cnt`. Later requests are ignored until the next `ch_start`.
- R11: A host write during a job changes only the reload copy. A new block size takes effect at the next `req`. A new count takes effect at the next start or reload.
- R12: A `ch_start` while the channel is active is ignored and does not reload the live count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Host write strobe |
| reg_sel | input | 1 | Register select: 0 block size, 1 transfer count |
| reg_wdata | input | 16 | Host write data |
| reg_rdata | output | 16 | Reload copy of the selected register |
| ch_start | input | 1 | Starts a job by loading the live transfer count |
| demand_mode | input | 1 | One unit per request when set |
| reload_en | input | 1 | Reload the count at terminal count instead of stopping |
| req | input | 1 | Transfer engine opens a block |
| unit_done | input | 1 | Transfer engine moved one data unit |
| ch_active | output | 1 | Channel enabled, a job is in progress |
| blk_busy | output | 1 | A block is open |
| blk_done | output | 1 | One-cycle pulse at block completion |
| term_cnt | output | 1 | One-cycle pulse at job completion |

## Verification
The assertions check properties that hold on every cycle. `blk_done` never lasts two cycles, and `term_cnt` never appears without `blk_done`. A stray unit pulse never completes a block. An open block always implies an active channel. The channel's state after terminal count always follows the reload setting. The exact unit and block counts can only be shown by the bench's scenarios, which compare every cycle against a behavioural model. These include the 16-unit block from a zero size, the 65536-block job from a zero count, the deferral of mid-job writes, and the ignored restart.

// File: rtl/dma_cnt_pkg.sv
package dma_cnt_pkg;
  localparam int unsigned BLK_FIELD_W = 4;
  localparam int unsigned CNT_FIELD_W = 16;

  typedef enum logic {
    SEL_BLOCK = 1'b0,
    SEL_COUNT = 1'b1
  } cnt_reg_e;
endpackage

// File: rtl/dma_reload_regs.sv
module dma_reload_regs
  import dma_cnt_pkg::*;
#(
  parameter int unsigned BS_W = BLK_FIELD_W,
  parameter int unsigned TC_W = CNT_FIELD_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  cnt_reg_e        sel,
  input  logic [TC_W-1:0] wdata,
  output logic [BS_W-1:0] bs_field,
  output logic [TC_W-1:0] tc_field,
  output logic [TC_W-1:0] rdata
);
  localparam int unsigned PAD_W = TC_W - BS_W;

  logic wr_blk;
  logic wr_cnt;

  assign wr_blk = wr && (sel == SEL_BLOCK);
  assign wr_cnt = wr && (sel == SEL_COUNT);

  // block size has no defined reset value
  always_ff @(posedge clk) begin
    if (wr_blk) bs_field <= wdata[BS_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tc_field <= '0;
    else if (wr_cnt) tc_field <= wdata;
  end

  always_comb begin
    if (sel == SEL_COUNT) rdata = tc_field;
    else                  rdata = {{PAD_W{1'b0}}, bs_field};
  end
endmodule

// File: rtl/dma_block_ctr.sv
module dma_block_ctr #(
  parameter int unsigned BS_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            demand,
  input  logic [BS_W-1:0] bs_field,
  input  logic            unit_done,
  input  logic            abort,
  output logic            busy,
  output logic            done_evt
);
  localparam int unsigned CW = BS_W + 1;

  logic [CW-1:0] units_left;

  function automatic logic [CW-1:0] units_for(input logic [BS_W-1:0] f,
                                               input logic dm);
    if (dm)       return CW'(1);
    if (f == '0)  return CW'(1) << BS_W;
    return {1'b0, f};
  endfunction

  assign done_evt = busy && unit_done && (units_left == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      units_left <= '0;
    end else if (abort) begin
      busy       <= 1'b0;
      units_left <= '0;
    end else if (load) begin
      busy       <= 1'b1;
      units_left <= units_for(bs_field, demand);
    end else if (busy && unit_done) begin
      units_left <= units_left - CW'(1);
      if (units_left == CW'(1)) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_xfer_ctr.sv
module dma_xfer_ctr #(
  parameter int unsigned TC_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            blk_evt,
  input  logic            reload_en,
  input  logic [TC_W-1:0] tc_field,
  output logic            active,
  output logic            last_evt
);
  localparam int unsigned CW = TC_W + 1;

  logic [CW-1:0] blocks_left;

  function automatic logic [CW-1:0] blocks_for(input logic [TC_W-1:0] f);
    if (f == '0) return CW'(1) << TC_W;
    return {1'b0, f};
  endfunction

  assign last_evt = blk_evt && (blocks_left == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active      <= 1'b0;
      blocks_left <= '0;
    end else if (start && !active) begin
      active      <= 1'b1;
      blocks_left <= blocks_for(tc_field);
    end else if (last_evt) begin
      if (reload_en) begin
        blocks_left <= blocks_for(tc_field);
      end else begin
        active      <= 1'b0;
        blocks_left <= '0;
      end
    end else if (blk_evt) begin
      blocks_left <= blocks_left - CW'(1);
    end
  end
endmodule

// File: rtl/dma_chan_counter.sv
module dma_chan_counter
  import dma_cnt_pkg::*;
#(
  parameter int unsigned BS_W = BLK_FIELD_W,
  parameter int unsigned TC_W = CNT_FIELD_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic            reg_sel,
  input  logic [TC_W-1:0] reg_wdata,
  output logic [TC_W-1:0] reg_rdata,
  input  logic            ch_start,
  input  logic            demand_mode,
  input  logic            reload_en,
  input  logic            req,
  input  logic            unit_done,
  output logic            ch_active,
  output logic            blk_busy,
  output logic            blk_done,
  output logic            term_cnt
);
  logic [BS_W-1:0] bs_field;
  logic [TC_W-1:0] tc_field;
  logic            req_ok;
  logic            blk_evt;
  logic            tc_evt;
  logic            stop_evt;
  cnt_reg_e        sel_e;

  assign sel_e    = cnt_reg_e'(reg_sel);
  assign req_ok   = req && ch_active && !blk_busy;
  assign stop_evt = tc_evt && !reload_en;

  dma_reload_regs #(.BS_W(BS_W), .TC_W(TC_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (reg_wr),
    .sel      (sel_e),
    .wdata    (reg_wdata),
    .bs_field (bs_field),
    .tc_field (tc_field),
    .rdata    (reg_rdata)
  );

  dma_block_ctr #(.BS_W(BS_W)) u_blk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (req_ok),
    .demand    (demand_mode),
    .bs_field  (bs_field),
    .unit_done (unit_done),
    .abort     (1'b0),
    .busy      (blk_busy),
    .done_evt  (blk_evt)
  );

  dma_xfer_ctr #(.TC_W(TC_W)) u_xfer (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (ch_start),
    .blk_evt   (blk_evt),
    .reload_en (reload_en),
    .tc_field  (tc_field),
    .active    (ch_active),
    .last_evt  (tc_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_done <= 1'b0;
      term_cnt <= 1'b0;
    end else begin
      blk_done <= blk_evt;
      term_cnt <= tc_evt;
    end
  end

  logic unused_stop;
  assign unused_stop = stop_evt;
endmodule

// File: rtl/dma_chan_counter_chk.sv
module dma_chan_counter_chk (
  input logic clk,
  input logic rst_n,
  input logic unit_done,
  input logic demand_mode,
  input logic reload_en,
  input logic ch_active,
  input logic blk_busy,
  input logic blk_done,
  input logic term_cnt,
  input logic req_ok
);
  // R3
  blk_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |=> !blk_done);

  // R7
  term_with_blk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    term_cnt |-> blk_done);

  // R10
  stop_at_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (term_cnt && !$past(reload_en)) |-> !ch_active);

  // R9
  keep_at_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (term_cnt && $past(reload_en)) |-> ch_active);

  // R6
  stray_unit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_done && !blk_busy) |=> !blk_done);

  // R6
  busy_in_job_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_busy |-> ch_active);

  // R5
  demand_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_busy && unit_done && $past(req_ok && demand_mode)) |=> blk_done);
endmodule

bind dma_chan_counter dma_chan_counter_chk i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .unit_done   (unit_done),
  .demand_mode (demand_mode),
  .reload_en   (reload_en),
  .ch_active   (ch_active),
  .blk_busy    (blk_busy),
  .blk_done    (blk_done),
  .term_cnt    (term_cnt),
  .req_ok      (req_ok)
);

// File: tb/test_dma_chan_counter.sv
`timescale 1ns/1ps
module test_dma_chan_counter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_sel = 1'b1;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        ch_start = 1'b0;
  logic        demand_mode = 1'b0;
  logic        reload_en = 1'b0;
  logic        req = 1'b0;
  logic        unit_done = 1'b0;
  logic        ch_active, blk_busy, blk_done, term_cnt;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;
  string phase = "R1";

  always #10 clk = ~clk;

  dma_chan_counter i_dma_chan_counter (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ch_start(ch_start),
    .demand_mode(demand_mode), .reload_en(reload_en), .req(req),
    .unit_done(unit_done), .ch_active(ch_active), .blk_busy(blk_busy),
    .blk_done(blk_done), .term_cnt(term_cnt)
  );

  // behavioural reference model
  int m_active = 0, m_busy = 0, m_units = 0, m_blocks = 0;
  int m_bs = -1, m_tc = 0, m_bd = 0, m_term = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_active = 0; m_busy = 0; m_units = 0; m_blocks = 0;
      m_tc = 0; m_bd = 0; m_term = 0;
    end else begin
      bit rq, st;
      rq = req && m_active != 0 && m_busy == 0;
      st = ch_start && m_active == 0;
      m_bd = 0; m_term = 0;
      if (unit_done && m_busy != 0) begin
        m_units--;
        if (m_units == 0) begin
          m_busy = 0; m_bd = 1;
          if (m_blocks == 1) begin
            m_term = 1;
            if (reload_en) m_blocks = (m_tc == 0) ? 65536 : m_tc;
            else begin m_blocks = 0; m_active = 0; end
          end else m_blocks--;
        end
      end
      if (rq) begin
        m_busy = 1;
        m_units = demand_mode ? 1 : ((m_bs == 0) ? 16 : m_bs);
      end
      if (st) begin
        m_active = 1;
        m_blocks = (m_tc == 0) ? 65536 : m_tc;
      end
      if (reg_wr) begin
        if (reg_sel) m_tc = reg_wdata;
        else m_bs = reg_wdata[3:0];
      end
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(ch_active == (m_active != 0), {phase, " ch_active"}, ch_active, m_active);
      check(blk_busy == (m_busy != 0), {phase, " blk_busy"}, blk_busy, m_busy);
      check(blk_done == (m_bd != 0), {phase, " blk_done"}, blk_done, m_bd);
      check(term_cnt == (m_term != 0), {phase, " term_cnt"}, term_cnt, m_term);
      if (reg_sel) check(reg_rdata == m_tc[15:0], {phase, " rdata"}, reg_rdata, m_tc);
      else if (m_bs >= 0) check(reg_rdata == 16'(m_bs), {phase, " rdata"}, reg_rdata, m_bs);
    end
  end

  task automatic cyc();
    @(negedge clk); #1;
  endtask

  task automatic host_wr(bit sel, int data);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = 16'(data);
    cyc();
    reg_wr = 1'b0;
  endtask

  task automatic go();
    ch_start = 1'b1; cyc(); ch_start = 1'b0;
  endtask

  task automatic do_units(int exp, string tag, output bit term);
    int n = 0;
    term = 1'b0;
    unit_done = 1'b1;
    while (n < 40) begin
      cyc(); n++;
      if (blk_done) begin term = term_cnt; break; end
    end
    unit_done = 1'b0;
    check(n == exp, {tag, " units per block"}, n, exp);
  endtask

  task automatic do_block(int exp, string tag, output bit term);
    req = 1'b1; cyc(); req = 1'b0;
    do_units(exp, tag, term);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired in %s", phase);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit t;
    int nb;
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    // R1
    phase = "R1";
    check(!ch_active && !blk_busy && !blk_done && !term_cnt, "R1 outputs idle", ch_active, 0);
    check(reg_rdata == 16'd0, "R1 count reads zero", reg_rdata, 0);

    // R2 programming and readback
    phase = "R2";
    host_wr(1'b0, 16'hFFF5);
    host_wr(1'b1, 3);
    reg_sel = 1'b0; cyc();
    check(reg_rdata == 16'd5, "R2 block size readback", reg_rdata, 5);
    reg_sel = 1'b1; cyc();
    check(reg_rdata == 16'd3, "R2 count readback", reg_rdata, 3);

    // R3 / R7 / R10
    phase = "R3";
    go();
    do_block(5, "R3", t); check(!t, "R7 no term at block 1", t, 0);
    reg_sel = 1'b0; cyc();
    check(reg_rdata == 16'd5, "R2 readback mid-job", reg_rdata, 5);
    reg_sel = 1'b1;
    do_block(5, "R3", t); check(!t, "R7 no term at block 2", t, 0);
    phase = "R7";
    do_block(5, "R7", t); check(t, "R7 term on last block", t, 1);
    check(!ch_active, "R10 channel stopped", ch_active, 0);
    phase = "R10";
    req = 1'b1; cyc(); req = 1'b0; cyc();
    check(!blk_busy, "R10 req ignored after stop", blk_busy, 0);

    // R4
    phase = "R4";
    host_wr(1'b0, 0); host_wr(1'b1, 1);
    go();
    do_block(16, "R4", t); check(t, "R4 single block job ends", t, 1);

    // R5
    phase = "R5";
    host_wr(1'b0, 7); host_wr(1'b1, 2);
    demand_mode = 1'b1;
    go();
    do_block(1, "R5", t);
    do_block(1, "R5", t); check(t, "R5 term after two", t, 1);
    demand_mode = 1'b0;

    // R6 / R12
    phase = "R6";
    host_wr(1'b0, 3); host_wr(1'b1, 2);
    go();
    unit_done = 1'b1; repeat (3) cyc(); unit_done = 1'b0; cyc();
    check(!blk_busy && !blk_done, "R6 stray units ignored", blk_busy, 0);
    do_block(3, "R6", t);
    phase = "R12";
    go();
    check(ch_active, "R12 still active", ch_active, 1);
    do_block(3, "R12", t); check(t, "R12 restart did not reload", t, 1);

    // R11
    phase = "R11";
    host_wr(1'b0, 4); host_wr(1'b1, 3);
    go();
    req = 1'b1; cyc(); req = 1'b0;
    host_wr(1'b0, 2);
    host_wr(1'b1, 9);
    req = 1'b1; cyc(); req = 1'b0;
    check(blk_busy, "R6 req during block kept block", blk_busy, 1);
    do_units(4, "R11 current block", t);
    do_block(2, "R11 next block", t);
    check(reg_rdata == 16'd9, "R11 reload copy reads new", reg_rdata, 9);
    do_block(2, "R11", t); check(t, "R11 count not changed live", t, 1);

    // R9
    phase = "R9";
    host_wr(1'b0, 1); host_wr(1'b1, 2);
    reload_en = 1'b1;
    go();
    do_block(1, "R9", t);
    do_block(1, "R9", t); check(t && ch_active, "R9 term keeps channel", ch_active, 1);
    do_block(1, "R9", t); check(!t, "R9 reloaded count", t, 0);
    do_block(1, "R9", t); check(t, "R9 second term", t, 1);
    reload_en = 1'b0;
    do_block(1, "R9", t);
    do_block(1, "R10", t); check(!ch_active, "R10 stop after reload off", ch_active, 0);

    // R8
    phase = "R8";
    host_wr(1'b1, 0);
    demand_mode = 1'b1;
    go();
    nb = 0;
    req = 1'b1; unit_done = 1'b1;
    for (int i = 0; i < 140000; i++) begin
      cyc();
      if (blk_done) nb++;
      if (term_cnt) break;
    end
    req = 1'b0; unit_done = 1'b0; demand_mode = 1'b0;
    check(nb == 65536, "R8 zero count gives 65536 blocks", nb, 65536);
    cyc();
    check(!ch_active, "R8 channel ends", ch_active, 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule